// File: doc/BRIEF.md
# Ethernet Frame Receiver with Address and CRC Filtering

This block sits behind a byte-wide receive bus from an Ethernet PHY. It waits for a run of preamble bytes followed by the start-of-frame delimiter, then takes every following byte as part of the frame until the data-valid strobe drops. While the frame streams in, each byte is written to an internal receive buffer at its position, a CRC-32 is updated one byte per clock, and the first six bytes are compared with a programmable station address and with the all-ones broadcast address.

When data-valid falls, the block decides in a single cycle. The frame is kept only if the CRC residue is correct, the destination matched, no receive error was flagged during the burst and the length is within limits. A kept frame produces a one-cycle valid pulse with the payload length, which excludes the four check bytes. A rejected frame leaves no trace at the ports: no pulse and no error flag. The consumer reads the kept frame from the buffer through a registered read port before the next frame arrives.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset, `frm_valid` is low and stays low while the receive bus is idle.
- R2: A frame starts only after one or more 0x55 bytes directly followed by 0xD5 on `rx_data` with `rx_dv` high; a burst whose first byte is not 0x55, or with any other byte before 0xD5, is ignored until `rx_dv` drops.
- R3: A frame is kept only when the CRC-32 (reflected, initial value all ones, check bytes sent low byte first) taken over all bytes after 0xD5 leaves the residue 0xC704DD7B in unreflected form; any corrupted byte drops the frame.
- R4: The first six bytes after 0xD5 form the destination; the first of them is compared with `local_mac[47:40]` and the sixth with `local_mac[7:0]`, and a frame that matches neither this address nor broadcast is dropped.
- R5: A frame whose destination is FF:FF:FF:FF:FF:FF is kept regardless of `local_mac`.
- R6: A burst in which `rx_er` is high at any clock with `rx_dv` high is dropped.
- R7: A frame of up to 1518 bytes after 0xD5 (check bytes included) is kept; a longer one is dropped.
- R8: For a kept frame, `frm_valid` is high for exactly one cycle, in the cycle after the first clock at which `rx_dv` is sampled low, with `frm_len` equal to the byte count after 0xD5 minus 4.
- R9: Byte i after 0xD5 (i counted from 0) is stored at buffer address i; `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is sampled.
- R10: A frame shorter than 18 bytes after 0xD5 is dropped.
- R11: A dropped frame gives no pulse on `frm_valid`, and the next correct frame is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_er | input | 1 | Receive error from the PHY |
| rx_data | input | 8 | Receive byte from the PHY |
| local_mac | input | 48 | Station address, first wire byte in bits 47:40 |
| rd_addr | input | 11 | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle after address |
| frm_valid | output | 1 | One-cycle pulse for a kept frame |
| frm_len | output | 11 | Payload length of the kept frame, check bytes excluded |

## Verification
A wrong state in the framing logic shows as a missing or extra valid pulse within one clock of data-valid falling, because the decision is registered exactly once per burst. A corrupted CRC register or address flag turns a good frame into a silent drop, or lets a bad one through, which the pulse counter of the stimulus sees at the end of that frame. Length and buffer address errors show as a wrong `frm_len` on the same pulse or as a wrong byte read back from the buffer right after it.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_BODY,
      ST_DRAIN
   } rx_state_e;

   localparam logic [7:0]  PRE_BYTE  = 8'h55;
   localparam logic [7:0]  SFD_BYTE  = 8'hD5;
   localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
   localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;
   localparam int          FCS_BYTES = 4;
   localparam int          DA_BYTES  = 6;

   function automatic logic [31:0] crc32_step(input logic [31:0] c_in,
                                              input logic [7:0]  b);
      logic [31:0] c;
      c = c_in ^ {24'h0, b};
      for (int k = 0; k < 8; k++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
   import eth_rx_pkg::*;
#(
   parameter logic [31:0] RESIDUE = 32'hC704DD7B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   input  logic       en,
   input  logic [7:0] data,
   output logic       residue_ok
);

   logic [31:0] crc_q;
   logic [31:0] crc_rev;

   always_ff @(posedge clk) begin
      if (!rst_n || init) begin
         crc_q <= CRC_SEED;
      end else if (en) begin
         crc_q <= crc32_step(crc_q, data);
      end
   end

   for (genvar i = 0; i < 32; i++) begin : g_rev
      assign crc_rev[i] = crc_q[31-i];
   end

   assign residue_ok = (crc_rev == RESIDUE);

endmodule

// File: rtl/eth_rx_da_match.sv
module eth_rx_da_match
   import eth_rx_pkg::*;
#(
   parameter int IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       data,
   input  logic [47:0]      local_mac,
   output logic             hit
);

   logic [DA_BYTES-1:0] own_b;
   logic [DA_BYTES-1:0] bc_b;

   for (genvar i = 0; i < DA_BYTES; i++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n || start) begin
            own_b[i] <= 1'b0;
            bc_b[i]  <= 1'b0;
         end else if (en && (idx == IDX_W'(i))) begin
            own_b[i] <= (data == local_mac[47-8*i -: 8]);
            bc_b[i]  <= (data == 8'hFF);
         end
      end
   end

   assign hit = (&own_b) | (&bc_b);

endmodule

// File: rtl/eth_rx_buf.sv
module eth_rx_buf #(
   parameter int DEPTH = 2048,
   parameter int AW    = 11
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
   import eth_rx_pkg::*;
#(
   parameter int          MAX_FRAME = 1518,
   parameter int          MIN_FRAME = 18,
   parameter logic [31:0] RESIDUE   = 32'hC704DD7B,
   localparam int         LEN_W     = $clog2(MAX_FRAME + 2),
   localparam int         BUF_AW    = $clog2(MAX_FRAME),
   localparam int         BUF_DEPTH = 1 << BUF_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_dv,
   input  logic              rx_er,
   input  logic [7:0]        rx_data,
   input  logic [47:0]       local_mac,
   input  logic [BUF_AW-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              frm_valid,
   output logic [LEN_W-1:0]  frm_len
);

   initial begin
      assert (MIN_FRAME >= DA_BYTES + FCS_BYTES)
         else $error("MIN_FRAME too small to hold address and check bytes");
      assert (MAX_FRAME > MIN_FRAME)
         else $error("MAX_FRAME must exceed MIN_FRAME");
   end

   rx_state_e        st_q;
   logic [LEN_W-1:0] cnt_q;
   logic             err_q;
   logic             sof;
   logic             body_en;
   logic             eof;
   logic             crc_ok;
   logic             da_hit;
   logic             keep;
   logic             buf_we;

   assign sof     = (st_q == ST_PRE) && rx_dv && (rx_data == SFD_BYTE);
   assign body_en = (st_q == ST_BODY) && rx_dv;
   assign eof     = (st_q == ST_BODY) && !rx_dv;
   assign buf_we  = body_en && (cnt_q < LEN_W'(MAX_FRAME));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (rx_dv) begin
                  st_q <= (rx_data == PRE_BYTE) ? ST_PRE : ST_DRAIN;
               end
            end
            ST_PRE: begin
               if (!rx_dv) begin
                  st_q <= ST_IDLE;
               end else if (rx_data == SFD_BYTE) begin
                  st_q <= ST_BODY;
               end else if (rx_data != PRE_BYTE) begin
                  st_q <= ST_DRAIN;
               end
            end
            ST_BODY: begin
               if (!rx_dv) begin
                  st_q <= ST_IDLE;
               end
            end
            default: begin
               if (!rx_dv) begin
                  st_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || sof) begin
         cnt_q <= '0;
      end else if (body_en && (cnt_q <= LEN_W'(MAX_FRAME))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if ((st_q == ST_IDLE) && rx_dv) begin
         err_q <= rx_er;
      end else if (rx_dv && rx_er) begin
         err_q <= 1'b1;
      end
   end

   eth_rx_crc #(
      .RESIDUE (RESIDUE)
   ) u_crc (
      .clk        (clk),
      .rst_n      (rst_n),
      .init       (sof),
      .en         (body_en),
      .data       (rx_data),
      .residue_ok (crc_ok)
   );

   eth_rx_da_match #(
      .IDX_W (LEN_W)
   ) u_da (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (sof),
      .en        (body_en),
      .idx       (cnt_q),
      .data      (rx_data),
      .local_mac (local_mac),
      .hit       (da_hit)
   );

   eth_rx_buf #(
      .DEPTH (BUF_DEPTH),
      .AW    (BUF_AW)
   ) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .waddr (cnt_q[BUF_AW-1:0]),
      .wdata (rx_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   assign keep = crc_ok && da_hit && !err_q
              && (cnt_q >= LEN_W'(MIN_FRAME))
              && (cnt_q <= LEN_W'(MAX_FRAME));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frm_valid <= 1'b0;
         frm_len   <= '0;
      end else begin
         frm_valid <= eof && keep;
         if (eof && keep) begin
            frm_len <= cnt_q - LEN_W'(FCS_BYTES);
         end
      end
   end

endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk #(
   parameter int MAX_FRAME = 1518,
   parameter int MIN_FRAME = 18,
   parameter int LEN_W     = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_dv,
   input logic             rx_er,
   input logic             frm_valid,
   input logic [LEN_W-1:0] frm_len
);

   logic dv_prev;
   logic burst_er;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dv_prev  <= 1'b0;
         burst_er <= 1'b0;
      end else begin
         dv_prev <= rx_dv;
         if (rx_dv && !dv_prev) begin
            burst_er <= rx_er;
         end else if (rx_dv && rx_er) begin
            burst_er <= 1'b1;
         end
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !frm_valid); // R8

   AST_PULSE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> (!$past(rx_dv) && $past(rx_dv, 2))); // R8

   AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> (frm_len <= LEN_W'(MAX_FRAME - 4))); // R7

   AST_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> (frm_len >= LEN_W'(MIN_FRAME - 4))); // R10

   AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> !burst_er); // R6

endmodule

bind eth_rx_filter eth_rx_filter_chk #(
   .MAX_FRAME (MAX_FRAME),
   .MIN_FRAME (MIN_FRAME),
   .LEN_W     (LEN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_dv     (rx_dv),
   .rx_er     (rx_er),
   .frm_valid (frm_valid),
   .frm_len   (frm_len)
);

// File: tb/eth_rx_filter_tb.sv
module eth_rx_filter_tb;

   localparam int CLK_PERIOD = 8;
   localparam int LEN_W      = 11;
   localparam int AW         = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_dv = 1'b0;
   logic             rx_er = 1'b0;
   logic [7:0]       rx_data = 8'h00;
   logic [47:0]      local_mac = 48'h02_1A_2B_3C_4D_5E;
   logic [AW-1:0]    rd_addr = '0;
   logic [7:0]       rd_data;
   logic             frm_valid;
   logic [LEN_W-1:0] frm_len;

   int total = 0;
   int bad   = 0;
   int pulses = 0;
   int last_len = 0;
   logic [7:0] fb [0:1599];

   eth_rx_filter u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_dv     (rx_dv),
      .rx_er     (rx_er),
      .rx_data   (rx_data),
      .local_mac (local_mac),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .frm_valid (frm_valid),
      .frm_len   (frm_len)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (frm_valid) begin
         pulses++;
         last_len = int'(frm_len);
      end
   end

   function automatic logic [31:0] crc_upd(input logic [31:0] c_in, input logic [7:0] b);
      logic [31:0] c;
      c = c_in ^ {24'h0, b};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      return c;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // fill fb with destination, random body and a correct check field; n counts all bytes
   task automatic build(input logic [47:0] da, input int n);
      logic [31:0] c;
      for (int i = 0; i < n - 4; i++) fb[i] = (i < 6) ? da[47-8*i -: 8] : 8'($urandom);
      c = 32'hFFFFFFFF;
      for (int i = 0; i < n - 4; i++) c = crc_upd(c, fb[i]);
      c = ~c;
      for (int i = 0; i < 4; i++) fb[n-4+i] = c[8*i +: 8];
   endtask

   task automatic send(input int npre, input logic sfd, input int n, input int er_at);
      for (int i = 0; i < npre; i++) begin
         @(negedge clk); rx_dv = 1'b1; rx_er = 1'b0; rx_data = 8'h55;
      end
      if (sfd) begin
         @(negedge clk); rx_dv = 1'b1; rx_data = 8'hD5;
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rx_dv = 1'b1; rx_data = fb[i]; rx_er = (i == er_at);
      end
      @(negedge clk); rx_dv = 1'b0; rx_er = 1'b0; rx_data = 8'h00;
      repeat (3) @(negedge clk);
   endtask

   task automatic run(input string req, input int npre, input logic sfd, input int n,
                      input int er_at, input logic exp_keep);
      int p0;
      p0 = pulses;
      send(npre, sfd, n, er_at);
      check(req, pulses - p0, exp_keep ? 1 : 0);
      if (exp_keep) check(req, last_len, n - 4);
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk); rd_addr = AW'(a);
      @(negedge clk); d = rd_data;
   endtask

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      check("R1 idle valid", int'(frm_valid), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 idle after reset", pulses, 0);

      build(local_mac, 64);
      run("R3 R8 unicast good", 7, 1'b1, 64, -1, 1'b1);
      for (int i = 0; i < 64; i += 9) begin
         rd(i, d);
         check("R9 buffer byte", int'(d), int'(fb[i]));
      end
      rd(63, d);
      check("R9 last check byte", int'(d), int'(fb[63]));

      build(48'hFFFF_FFFF_FFFF, 40);
      run("R5 broadcast", 7, 1'b1, 40, -1, 1'b1);

      build(local_mac ^ 48'h1, 40);
      run("R4 last address byte differs", 7, 1'b1, 40, -1, 1'b0);
      build(local_mac ^ 48'h0100_0000_0000, 40);
      run("R4 first address byte differs", 7, 1'b1, 40, -1, 1'b0);

      build(local_mac, 50);
      fb[20] = fb[20] ^ 8'h10;
      run("R3 corrupted byte", 7, 1'b1, 50, -1, 1'b0);
      build(local_mac, 50);
      run("R11 good after drop", 7, 1'b1, 50, -1, 1'b1);

      build(local_mac, 50);
      run("R6 rx_er in body", 7, 1'b1, 50, 30, 1'b0);

      build(local_mac, 1518);
      run("R7 max length", 7, 1'b1, 1518, -1, 1'b1);
      build(local_mac, 1519);
      run("R7 over max", 7, 1'b1, 1519, -1, 1'b0);

      build(local_mac, 18);
      run("R10 min length", 7, 1'b1, 18, -1, 1'b1);
      build(local_mac, 17);
      run("R10 below min", 7, 1'b1, 17, -1, 1'b0);

      build(local_mac, 30);
      run("R2 single preamble byte", 1, 1'b1, 30, -1, 1'b1);
      run("R2 no preamble", 0, 1'b1, 30, -1, 1'b0);
      fb[0] = 8'h12;
      run("R2 junk before preamble", 0, 1'b0, 1, -1, 1'b0);
      build(local_mac, 30);
      run("R2 no delimiter", 7, 1'b0, 30, -1, 1'b0);

      for (int t = 0; t < 24; t++) begin
         int n, kind, er_at;
         logic keep;
         n = 18 + int'($urandom % 120);
         kind = int'($urandom % 5);
         er_at = -1;
         keep = 1'b1;
         case (kind)
            0: build(local_mac, n);
            1: build(48'hFFFF_FFFF_FFFF, n);
            2: begin build(48'h0A0B_0C0D_0E0F, n); keep = 1'b0; end
            3: begin build(local_mac, n); fb[$urandom % n] ^= 8'h01; keep = 1'b0; end
            default: begin build(local_mac, n); er_at = int'($urandom % n); keep = 1'b0; end
         endcase
         run("R3 R4 R5 R6 random frame", 1 + int'($urandom % 7), 1'b1, n, er_at, keep);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule